// File: doc/BRIEF.md
# Broadcast Sequence Pulse Generator

This block watches an 8-bit broadcast code and two strobe lines delivered by a timing receiver. It turns two specific code and strobe combinations into two level signals, sequence-reset and sequence-test. These signals are distributed to a large number of front-end chips. The block runs on the 40 MHz system clock.

A recognised command does not give a single pulse, and it does not give a steady level either. While the command is held, the matching output is high for a long window (3 us by default). It then goes low for a gap of one or two cycles and comes back. This pattern repeats for as long as the command stays applied.

When the command disappears, the output falls at the next clock edge and the timing restarts from zero. If the command changes from one kind to the other, the new output begins a fresh window. Both outputs come straight from flip-flops, so the fan-out sees clean levels.

Top module: `seqgen_top`

## Requirements
- R1: When `bcast` equals 8'h08 and `strobe1` is high at a clock edge, `seq_rst` is high from that edge on. `strobe2` has no effect on this command.
- R2: When `bcast` equals 8'h80, `strobe2` is high and `strobe1` is low at a clock edge, `seq_tst` is high from that edge on.
- R3: Any other combination leaves both outputs low. This covers other code values, code 8'h08 without `strobe1`, and code 8'h80 without `strobe2`.
- R4: `seq_rst` and `seq_tst` are never high in the same cycle. A high `strobe1` blocks the test command, so the reset request takes priority.
- R5: Under a held command, the active output stays high for exactly `HOLD_CYCLES` cycles (default 120, which is 3 us at 40 MHz).
- R6: After the active window, the output is low for exactly `GAP_CYCLES` cycles (default 1, and 2 is allowed). It then rises again for another full window, and this repeats.
- R7: When the command is removed, its output is low at the next clock edge and the counters clear. Applying the command again gives a full-length window.
- R8: A direct change from one command to the other drops the old output at that edge and starts a full window on the new output.
- R9: A synchronous active-high `rst` forces both outputs low at the next edge and clears the timing. A command still held when reset is released starts a full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| bcast | input | 8 | Broadcast code from the timing receiver |
| strobe1 | input | 1 | First broadcast strobe; qualifies the reset code |
| strobe2 | input | 1 | Second broadcast strobe; qualifies the test code |
| seq_rst | output | 1 | Registered sequence-reset level |
| seq_tst | output | 1 | Registered sequence-test level |

## Verification
The assertions assume that the code and the strobes are stable around each rising clock edge. They also assume that `rst` is high from time zero and holds for at least one edge, because the reset property and every `$past` term depend on this. The bench meets both assumptions. It asserts reset before the first edge and changes every input only on falling edges. It keeps `GAP_CYCLES` within 1 to 2 on both instances, so the gap counter assertion holds for the parameter values the block supports.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    localparam logic [7:0] CODE_SRST = 8'h08;
    localparam logic [7:0] CODE_STST = 8'h80;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_SRST = 2'd1,
        CMD_STST = 2'd2
    } cmd_e;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } phase_e;

    typedef struct packed {
        logic srst;
        logic stst;
    } seqout_t;

    // Reset request is tested first; strobe1 high also vetoes the test code.
    function automatic cmd_e decode_cmd(input logic [7:0] code,
                                        input logic s1,
                                        input logic s2);
        if (code == CODE_SRST && s1)
            return CMD_SRST;
        if (code == CODE_STST && s2 && !s1)
            return CMD_STST;
        return CMD_IDLE;
    endfunction

    function automatic seqout_t drive_for(input cmd_e c);
        seqout_t o;
        o.srst = (c == CMD_SRST);
        o.stst = (c == CMD_STST);
        return o;
    endfunction

endpackage

// File: rtl/seqgen_decode.sv
module seqgen_decode
    import seqgen_pkg::*;
(
    input  logic [7:0] code,
    input  logic       s1,
    input  logic       s2,
    output cmd_e       cmd
);

    always_comb begin
        cmd = decode_cmd(code, s1, s2);
    end

endmodule

// File: rtl/seqgen_timer.sv
module seqgen_timer
    import seqgen_pkg::*;
#(
    parameter int HOLD_CYCLES = 120,
    parameter int GAP_CYCLES  = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  cmd_e    cmd,
    output seqout_t out_q
);

    localparam int MAX_LIM = (HOLD_CYCLES > GAP_CYCLES) ? HOLD_CYCLES : GAP_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] GAP_LIM  = CNT_W'(GAP_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    cmd_e             cur_q, cur_n;
    phase_e           ph_q, ph_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             on_n;
    seqout_t          out_n;

    always_comb begin
        cur_n = cur_q;
        ph_n  = ph_q;
        cnt_n = cnt_q;
        on_n  = 1'b0;
        if (cmd == CMD_IDLE) begin
            cur_n = CMD_IDLE;
            ph_n  = PH_ON;
            cnt_n = '0;
        end else if (cmd != cur_q) begin
            cur_n = cmd;
            ph_n  = PH_ON;
            cnt_n = ONE;
            on_n  = 1'b1;
        end else if (ph_q == PH_ON) begin
            if (cnt_q >= HOLD_LIM) begin
                ph_n  = PH_OFF;
                cnt_n = ONE;
                on_n  = 1'b0;
            end else begin
                cnt_n = cnt_q + ONE;
                on_n  = 1'b1;
            end
        end else begin
            if (cnt_q >= GAP_LIM) begin
                ph_n  = PH_ON;
                cnt_n = ONE;
                on_n  = 1'b1;
            end else begin
                cnt_n = cnt_q + ONE;
                on_n  = 1'b0;
            end
        end
        out_n = on_n ? drive_for(cur_n) : seqout_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CMD_IDLE;
            ph_q  <= PH_ON;
            cnt_q <= '0;
            out_q <= '0;
        end else begin
            cur_q <= cur_n;
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
            out_q <= out_n;
        end
    end

    // R5: the window counter never runs past its limit
    assert_hold_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ON) |-> (cnt_q <= HOLD_LIM));

    // R6: the gap counter never runs past its limit
    assert_gap_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_OFF) |-> (cnt_q <= GAP_LIM && cnt_q != '0));

    // R7: an active command always has a running count
    assert_count_live_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_q != CMD_IDLE) |-> (cnt_q != '0));

endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
    import seqgen_pkg::*;
#(
    parameter int HOLD_CYCLES = 120,
    parameter int GAP_CYCLES  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bcast,
    input  logic       strobe1,
    input  logic       strobe2,
    output logic       seq_rst,
    output logic       seq_tst
);

    cmd_e    cmd;
    seqout_t lvl;

    seqgen_decode u_decode (
        .code (bcast),
        .s1   (strobe1),
        .s2   (strobe2),
        .cmd  (cmd)
    );

    seqgen_timer #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .GAP_CYCLES  (GAP_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .out_q (lvl)
    );

    assign seq_rst = lvl.srst;
    assign seq_tst = lvl.stst;

    // R1: a rising reset level follows a qualified reset code
    assert_srst_source_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_rst) |-> $past(bcast == CODE_SRST && strobe1));

    // R2: a rising test level follows a qualified test code with strobe1 low
    assert_stst_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_tst) |-> $past(bcast == CODE_STST && strobe2 && !strobe1));

    // R4: the two levels are mutually exclusive
    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(seq_rst && seq_tst));

    // R7: removing the reset command drops its level at the next edge
    assert_srst_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !(bcast == CODE_SRST && strobe1) |=> !seq_rst);

    // R7: removing the test command drops its level at the next edge
    assert_stst_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !(bcast == CODE_STST && strobe2 && !strobe1) |=> !seq_tst);

    // R9: reset clears both levels
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!seq_rst && !seq_tst));

endmodule

// File: tb/seqgen_top_test.sv
module seqgen_top_test;

    localparam int CLK_PERIOD = 25;
    localparam int HOLD_A = 120;
    localparam int GAP_A  = 1;
    localparam int HOLD_B = 6;
    localparam int GAP_B  = 2;
    localparam int NVEC   = 9;

    // {code, strobe1, strobe2, exp_rst, exp_tst}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h08, 1'b1, 1'b0, 1'b1, 1'b0},   // R1
        {8'h08, 1'b1, 1'b1, 1'b1, 1'b0},   // R1 strobe2 irrelevant
        {8'h80, 1'b0, 1'b1, 1'b0, 1'b1},   // R2
        {8'h80, 1'b1, 1'b1, 1'b0, 1'b0},   // R4 strobe1 vetoes test
        {8'h80, 1'b0, 1'b0, 1'b0, 1'b0},   // R3
        {8'h08, 1'b0, 1'b1, 1'b0, 1'b0},   // R3
        {8'h18, 1'b1, 1'b0, 1'b0, 1'b0},   // R3
        {8'h81, 1'b0, 1'b1, 1'b0, 1'b0},   // R3
        {8'h00, 1'b1, 1'b1, 1'b0, 1'b0}    // R3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bcast = 8'h00;
    logic       strobe1 = 1'b0;
    logic       strobe2 = 1'b0;
    logic       seq_rst, seq_tst, b_rst, b_tst;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqgen_top #(.HOLD_CYCLES(HOLD_A), .GAP_CYCLES(GAP_A)) uut (
        .clk(clk), .rst(rst), .bcast(bcast), .strobe1(strobe1), .strobe2(strobe2),
        .seq_rst(seq_rst), .seq_tst(seq_tst)
    );

    seqgen_top #(.HOLD_CYCLES(HOLD_B), .GAP_CYCLES(GAP_B)) uut_g2 (
        .clk(clk), .rst(rst), .bcast(bcast), .strobe1(strobe1), .strobe2(strobe2),
        .seq_rst(b_rst), .seq_tst(b_tst)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c, input logic a, input logic b);
        bcast = c; strobe1 = a; strobe2 = b;
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0: return seq_rst;
            1: return seq_tst;
            default: return b_tst;
        endcase
    endfunction

    // count consecutive samples at the given level, starting from the current one
    task automatic run_len(input int sel, input logic lvl, output int n);
        n = 0;
        while (sig(sel) === lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R9 reset state rst", int'(seq_rst), 0);
        check("R9 reset state tst", int'(seq_tst), 0);
        rst = 1'b0;
        @(negedge clk);

        // decode table
        for (int i = 0; i < NVEC; i++) begin
            drive(8'h00, 1'b0, 1'b0);
            @(negedge clk);
            drive(VEC[i][11:4], VEC[i][3], VEC[i][2]);
            @(negedge clk);
            check($sformatf("R1/R2/R3/R4 vec%0d rst", i), int'(seq_rst), int'(VEC[i][1]));
            check($sformatf("R1/R2/R3/R4 vec%0d tst", i), int'(seq_tst), int'(VEC[i][0]));
        end
        drive(8'h00, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // window and gap timing, default instance
        drive(8'h08, 1'b1, 1'b0);
        @(negedge clk);
        run_len(0, 1'b1, n); check("R5 first window", n, HOLD_A);
        run_len(0, 1'b0, n); check("R6 gap", n, GAP_A);
        run_len(0, 1'b1, n); check("R6 regenerated window", n, HOLD_A);
        run_len(0, 1'b0, n); check("R6 second gap", n, GAP_A);
        check("R4 tst quiet during reset cmd", int'(seq_tst), 0);

        // removal and reapplication (R7)
        repeat (40) @(negedge clk);
        drive(8'h08, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 drop on removal", int'(seq_rst), 0);
        drive(8'h08, 1'b1, 1'b0);
        @(negedge clk);
        run_len(0, 1'b1, n); check("R7 full window after reapply", n, HOLD_A);

        // command switch (R8)
        repeat (30) @(negedge clk);
        drive(8'h80, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 old level dropped", int'(seq_rst), 0);
        run_len(1, 1'b1, n); check("R8 new full window", n, HOLD_A);

        // reset mid-window (R9)
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset clears tst", int'(seq_tst), 0);
        repeat (2) @(negedge clk);
        check("R9 held in reset", int'(seq_tst), 0);
        rst = 1'b0;
        @(negedge clk);
        run_len(1, 1'b1, n); check("R9 full window after reset", n, HOLD_A);
        drive(8'h00, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // two-cycle gap instance
        drive(8'h80, 1'b0, 1'b1);
        @(negedge clk);
        run_len(2, 1'b1, n); check("R5 short window", n, HOLD_B);
        run_len(2, 1'b0, n); check("R6 two-cycle gap", n, GAP_B);
        run_len(2, 1'b1, n); check("R6 short regenerated window", n, HOLD_B);
        run_len(2, 1'b0, n); check("R6 second two-cycle gap", n, GAP_B);
        check("R4 rst quiet during test cmd", int'(b_rst), 0);
        drive(8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 idle after release", int'(seq_tst), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule